// File: doc/BRIEF.md
# Fuse Word Zeroization Sequencer

This block carries out one zeroize command at a time for a one-time-programmable fuse array. A command names a single 32-bit word by its address. The block compares that address with a fixed table of partitions. Each partition has a base, a size and a flag that says whether the partition may be cleared. If the target may be cleared, the block first drives every fuse of the partition's 64-bit clear marker to 1. The marker is the last two words of the partition. After that the block blows the target word and reads it back. It then reports how many bits of the target word read as 1.

The marker always goes first. If power is lost partway through, the partition is already flagged as cleared before any of its data has been destroyed. Marker words are written only for the first command that reaches a partition after reset; later commands to the same partition program just the target word. All fuse traffic passes over a request/acknowledge port that handles one word at a time. Every request is held until the fuse array acknowledges it.

Top module: `fuse_wipe_seq`

## Requirements
- R1: A command is accepted only when `cmd_valid` is high and bit 2 (zeroize) of `cmd_kind` is set. Bits 0 (read) and 1 (write) are ignored. A command with bit 2 clear causes no fuse request and leaves `busy` and `err` unchanged.
- R2: For a target in a clearable partition whose marker has not yet been written since reset, the block programs the marker words first, at base+size-2 and then base+size-1. It programs the target word after them. No marker word is programmed after the target word.
- R3: Every program request writes `prog_data` as all ones (32'hFFFF_FFFF) to exactly one word. `prog_req` and `prog_addr` stay unchanged until the cycle in which `prog_ack` is high.
- R4: Once a partition's marker has been programmed, later commands to that partition program only the target word. The "marker written" flag of a partition never clears except by reset.
- R5: A target that lies in a non-clearable partition (words 48..55), or in no partition at all (words 56..63 and 88..255), sets `err` in the following cycle. It raises no fuse or read request, and `busy` stays low.
- R6: A zeroize command that arrives while `busy` is high sets `err`. The operation already running completes unchanged.
- R7: After the target word is programmed, the block reads it back once. In the cycle after `rd_ack`, `done` is high for exactly one cycle and `blown_cnt` equals the number of 1 bits in `rd_data` (0..32).
- R8: `err` clears when a command is accepted and otherwise holds its value. `blown_cnt` changes only when `done` pulses.
- R9: After reset, `busy`, `done`, `err`, `prog_req`, `rd_req` and `blown_cnt` are zero, and every partition's "marker written" flag is cleared.
- R10: `busy` rises in the cycle after an accepted command and falls in the cycle in which `done` is high. `done` is never high together with `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_kind | input | 3 | Command bits: 0 read, 1 write, 2 zeroize |
| cmd_addr | input | 8 | Target word address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected command flag |
| blown_cnt | output | 6 | Number of target bits read back as 1 |
| prog_req | output | 1 | Word program request |
| prog_addr | output | 8 | Word program address |
| prog_data | output | 32 | Word program data |
| prog_ack | input | 1 | Program acknowledge |
| rd_req | output | 1 | Readback request |
| rd_addr | output | 8 | Readback address |
| rd_data | input | 32 | Readback data |
| rd_ack | input | 1 | Readback acknowledge |

## Verification
A stale or corrupted "marker written" flag appears in the very next program request. Either the marker addresses show up again for a partition that was already cleared, or the target address shows up without them. The bench compares the logged order of addresses as soon as `done` pulses. A wrong partition lookup shows up one cycle after the command, as a wrong `err` or `busy` value. A miscount appears on `blown_cnt` in the `done` cycle. The bench predicts that count from its own fuse model, which includes stuck bits.

// File: rtl/fuse_wipe_pkg.sv
// Shared constants and types for the zeroization sequencer.
// Assumes a word-addressed fuse array with a fixed partition layout.
package fuse_wipe_pkg;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int NUM_PART   = 4;
    localparam int MARK_BITS  = 64;
    localparam int MARK_WORDS = MARK_BITS / WORD_W;
    localparam int CNT_W      = $clog2(WORD_W + 1);
    localparam int PART_W     = (NUM_PART > 1) ? $clog2(NUM_PART) : 1;
    localparam int MK_W       = (MARK_WORDS > 1) ? $clog2(MARK_WORDS) : 1;
    localparam int ZERO_BIT   = 2;

    localparam logic [ADDR_W-1:0] PART_BASE [NUM_PART] = '{8'd0, 8'd16, 8'd48, 8'd64};
    localparam logic [ADDR_W:0]   PART_SIZE [NUM_PART] = '{9'd16, 9'd32, 9'd8, 9'd24};
    localparam logic [NUM_PART-1:0] PART_CLEARABLE = 4'b1011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARK,
        ST_DATA,
        ST_READ
    } wipe_state_t;
endpackage

// File: rtl/fuse_wipe_lookup.sv
// Maps a word address to its partition, its clear permission and its marker base.
// Assumes the partitions do not overlap; on no hit the other outputs are don't-care.
module fuse_wipe_lookup
    import fuse_wipe_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [PART_W-1:0] idx,
    output logic              clearable,
    output logic [ADDR_W-1:0] mark_base
);
    logic [NUM_PART-1:0] in_part;

    genvar g;
    generate
        for (g = 0; g < NUM_PART; g++) begin : g_range
            logic [ADDR_W:0] lo, hi;
            assign lo = {1'b0, PART_BASE[g]};
            assign hi = lo + PART_SIZE[g];
            // range compare for one partition
            assign in_part[g] = ({1'b0, addr} >= lo) && ({1'b0, addr} < hi);
        end
    endgenerate

    // encode the matching partition and fetch its attributes
    always_comb begin
        idx = '0;
        for (int i = NUM_PART - 1; i >= 0; i--) begin
            if (in_part[i]) idx = PART_W'(i);
        end
        hit       = |in_part;
        clearable = PART_CLEARABLE[idx];
        mark_base = ADDR_W'({1'b0, PART_BASE[idx]} + PART_SIZE[idx] - (ADDR_W+1)'(MARK_WORDS));
    end
endmodule

// File: rtl/fuse_wipe_marks.sv
// Holds one "marker written" flag per partition; flags only set, reset clears them.
module fuse_wipe_marks
    import fuse_wipe_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [PART_W-1:0]   set_idx,
    output logic [NUM_PART-1:0] flags
);
    // set the flag of the partition whose marker just completed
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else if (set_en) flags[set_idx] <= 1'b1;
    end
endmodule

// File: rtl/fuse_wipe_popcount.sv
// Counts the 1 bits of a readback word.
module fuse_wipe_popcount
    import fuse_wipe_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  ones
);
    // sum the set bits
    always_comb begin
        ones = '0;
        for (int i = 0; i < WORD_W; i++) ones = ones + CNT_W'(word[i]);
    end
endmodule

// File: rtl/fuse_wipe_seq.sv
// Zeroization sequencer: checks the target, programs the partition marker once,
// blows the target word, reads it back and reports its blown-bit count.
// Assumes the fuse array holds ack for one cycle per request.
module fuse_wipe_seq
    import fuse_wipe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [CNT_W-1:0]  blown_cnt,
    output logic              prog_req,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [WORD_W-1:0] prog_data,
    input  logic              prog_ack,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              rd_ack
);
    wipe_state_t         state_q;
    logic [ADDR_W-1:0]   tgt_q, mark_q;
    logic [PART_W-1:0]   part_q;
    logic [MK_W-1:0]     mk_cnt_q;
    logic                err_q, done_q;
    logic [CNT_W-1:0]    cnt_q;

    logic                zero_cmd, hit, hit_clear, set_mark, data_phase;
    logic [PART_W-1:0]   hit_idx;
    logic [ADDR_W-1:0]   hit_mark;
    logic [NUM_PART-1:0] marked_vec;
    logic [CNT_W-1:0]    rd_ones;
    logic                unused_kind;

    assign unused_kind = ^cmd_kind[1:0];
    assign zero_cmd    = cmd_valid & cmd_kind[ZERO_BIT];

    fuse_wipe_lookup u_lookup (
        .addr(cmd_addr), .hit(hit), .idx(hit_idx),
        .clearable(hit_clear), .mark_base(hit_mark)
    );

    assign set_mark = (state_q == ST_MARK) && prog_ack && (mk_cnt_q == MK_W'(MARK_WORDS - 1));

    fuse_wipe_marks u_marks (
        .clk(clk), .rst_n(rst_n), .set_en(set_mark),
        .set_idx(part_q), .flags(marked_vec)
    );

    fuse_wipe_popcount u_pop (.word(rd_data), .ones(rd_ones));

    // command acceptance, word sequencing and status update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            tgt_q    <= '0;
            mark_q   <= '0;
            part_q   <= '0;
            mk_cnt_q <= '0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
            cnt_q    <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (zero_cmd) begin
                        if (hit && hit_clear) begin
                            err_q    <= 1'b0;
                            tgt_q    <= cmd_addr;
                            part_q   <= hit_idx;
                            mark_q   <= hit_mark;
                            mk_cnt_q <= '0;
                            state_q  <= marked_vec[hit_idx] ? ST_DATA : ST_MARK;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_MARK: begin
                    if (prog_ack) begin
                        if (mk_cnt_q == MK_W'(MARK_WORDS - 1)) state_q <= ST_DATA;
                        else mk_cnt_q <= mk_cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (prog_ack) state_q <= ST_READ;
                end
                ST_READ: begin
                    if (rd_ack) begin
                        cnt_q   <= rd_ones;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (state_q != ST_IDLE && zero_cmd) err_q <= 1'b1;
        end
    end

    // drive the fuse port and status outputs from the registered state
    always_comb begin
        data_phase = (state_q == ST_DATA);
        prog_req   = (state_q == ST_MARK) || data_phase;
        prog_addr  = (state_q == ST_MARK) ? (mark_q + ADDR_W'(mk_cnt_q)) : tgt_q;
        prog_data  = '1;
        rd_req     = (state_q == ST_READ);
        rd_addr    = tgt_q;
        busy       = (state_q != ST_IDLE);
        done       = done_q;
        err        = err_q;
        blown_cnt  = cnt_q;
    end
endmodule

// File: rtl/fuse_wipe_seq_chk.sv
// Protocol and ordering checks for fuse_wipe_seq, attached by bind.
module fuse_wipe_seq_chk
    import fuse_wipe_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                done,
    input logic [CNT_W-1:0]    blown_cnt,
    input logic                prog_req,
    input logic [ADDR_W-1:0]   prog_addr,
    input logic                prog_ack,
    input logic                rd_req,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic                rd_ack,
    input logic                data_phase,
    input logic [PART_W-1:0]   part_q,
    input logic [NUM_PART-1:0] marked
);
    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req && !prog_ack |=> prog_req && $stable(prog_addr));

    a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

    a_r2_marker_first: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req && data_phase |-> marked[part_q]);

    a_r4_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (~marked & $past(marked)) == '0);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r5_req_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || rd_req) |-> busy);

    a_r3_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_req && rd_req));

    a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        blown_cnt <= CNT_W'(WORD_W));
endmodule

bind fuse_wipe_seq fuse_wipe_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .blown_cnt(blown_cnt),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_ack(prog_ack),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .data_phase(data_phase), .part_q(part_q), .marked(marked_vec)
);

// File: tb/fuse_wipe_seq_bench.sv
// Bench: fuse array model with stuck bits and random latency, directed and random commands.
module fuse_wipe_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_kind = 3'b000;
    logic [7:0]  cmd_addr = '0;
    logic        busy, done, err;
    logic [5:0]  blown_cnt;
    logic        prog_req, rd_req;
    logic [7:0]  prog_addr, rd_addr;
    logic [31:0] prog_data;
    logic        prog_ack = 1'b0, rd_ack = 1'b0;
    logic [31:0] rd_data = '0;

    int vectors = 0, miscompares = 0;
    bit finished = 0;
    logic [31:0] mem [256];
    int log_addr [8];
    int log_len = 0, rd_cnt = 0, data_bad = 0, lat = 0;
    bit bm_marked [4];

    always #2 clk = ~clk;

    fuse_wipe_seq u_fuse_wipe_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .busy(busy), .done(done), .err(err), .blown_cnt(blown_cnt),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data), .prog_ack(prog_ack),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ack(rd_ack)
    );

    function automatic logic [31:0] stuck(input int a);
        if (a % 3 == 0) return 32'h1 << (a % 32);
        if (a % 7 == 0) return 32'h0000_0300;
        return 32'h0;
    endfunction

    function automatic int part_of(input int a);
        if (a < 16) return 0;
        if (a < 48) return 1;
        if (a < 56) return 2;
        if (a >= 64 && a < 88) return 3;
        return -1;
    endfunction

    function automatic int mark_of(input int p);
        case (p)
            0: return 14;
            1: return 46;
            default: return 86;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // fuse array model: acknowledges each request after 0..2 cycles
    initial begin
        forever begin
            @(negedge clk);
            prog_ack = 1'b0;
            rd_ack   = 1'b0;
            if (rst_n && prog_req) begin
                if (lat == 0) begin
                    mem[prog_addr] = mem[prog_addr] | (prog_data & ~stuck(prog_addr));
                    if (prog_data != 32'hFFFF_FFFF) data_bad++;
                    if (log_len < 8) log_addr[log_len] = prog_addr;
                    log_len++;
                    prog_ack = 1'b1;
                    lat = $urandom % 3;
                end else lat--;
            end else if (rst_n && rd_req) begin
                if (lat == 0) begin
                    rd_data = mem[rd_addr];
                    rd_ack  = 1'b1;
                    rd_cnt++;
                    lat = $urandom % 3;
                end else lat--;
            end
        end
    end

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        foreach (bm_marked[i]) bm_marked[i] = 0;
        @(negedge clk);
        // R9: outputs after reset
        chk(!busy && !done && !err && !prog_req && !rd_req, "R9 idle after reset",
            {busy, done, err, prog_req, rd_req}, 0);
        chk(blown_cnt == 0, "R9 count after reset", blown_cnt, 0);
    endtask

    task automatic zeroize(input int addr, input logic [1:0] low_bits, input bit collide);
        int p = part_of(addr);
        bit ok = (p >= 0) && (p != 2);
        bit need_mark = ok && !bm_marked[ok ? p : 0];
        logic [31:0] pre = mem[addr];
        int exp_cnt = $countones(pre | ~stuck(addr));
        bit exp_err = 0;
        int c = 0;
        log_len = 0; rd_cnt = 0; data_bad = 0;
        cmd_valid = 1'b1; cmd_kind = {1'b1, low_bits}; cmd_addr = 8'(addr);
        @(negedge clk);
        cmd_valid = 1'b0;
        if (!ok) begin
            chk(err == 1'b1, "R5 err on rejected target", err, 1);
            chk(busy == 1'b0, "R5 busy stays low", busy, 0);
            repeat (4) @(negedge clk);
            chk(log_len == 0 && rd_cnt == 0, "R5 no fuse traffic", log_len + rd_cnt, 0);
            return;
        end
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        chk(err == 1'b0, "R8 err cleared on accept", err, 0);
        if (collide) begin
            cmd_valid = 1'b1; cmd_kind = 3'b100; cmd_addr = 8'd20;
            @(negedge clk);
            cmd_valid = 1'b0;
            chk(err == 1'b1, "R6 err on command while busy", err, 1);
            exp_err = 1;
        end
        while (!done && c < 100) begin
            @(negedge clk);
            c++;
        end
        chk(done == 1'b1, "R7 done pulse", done, 1);
        chk(blown_cnt == exp_cnt, "R7 blown count", blown_cnt, exp_cnt);
        chk(busy == 1'b0, "R10 busy low with done", busy, 0);
        chk(err == exp_err, "R8 err at completion", err, exp_err);
        chk(rd_cnt == 1, "R7 single readback", rd_cnt, 1);
        chk(data_bad == 0, "R3 all-ones data", data_bad, 0);
        if (need_mark) begin
            chk(log_len == 3, "R2 marker plus target count", log_len, 3);
            chk(log_addr[0] == mark_of(p) && log_addr[1] == mark_of(p) + 1,
                "R2 marker order", log_addr[0], mark_of(p));
            chk(log_addr[2] == addr, "R2 target after marker", log_addr[2], addr);
        end else begin
            chk(log_len == 1 && log_addr[0] == addr, "R4 target only", log_addr[0], addr);
        end
        bm_marked[p] = 1;
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);
        chk(blown_cnt == exp_cnt, "R8 count holds", blown_cnt, exp_cnt);
    endtask

    task automatic non_zero_cmd(input int addr, input logic [1:0] bits);
        logic e0 = err;
        log_len = 0; rd_cnt = 0;
        cmd_valid = 1'b1; cmd_kind = {1'b0, bits}; cmd_addr = 8'(addr);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && log_len == 0 && rd_cnt == 0, "R1 non-zeroize ignored",
            log_len + rd_cnt + busy, 0);
        chk(err == e0, "R1 err unchanged", err, e0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) mem[i] = $urandom & $urandom & $urandom;
        @(negedge clk);
        apply_reset();
        zeroize(16, 2'b00, 0);  // first word of partition 1, marker first
        zeroize(17, 2'b01, 0);  // marker already present
        zeroize(87, 2'b10, 0);  // target is a marker word of partition 3
        zeroize(50, 2'b00, 0);  // non-clearable partition
        non_zero_cmd(20, 2'b01);
        zeroize(60, 2'b00, 0);  // gap, unmapped
        zeroize(200, 2'b00, 0); // far unmapped
        non_zero_cmd(5, 2'b11);
        zeroize(47, 2'b00, 1);  // last word of partition 1, collision while busy
        zeroize(3, 2'b00, 1);   // partition 0 first time, collision
        apply_reset();
        zeroize(18, 2'b00, 0);  // R9: marker reprogrammed after reset
        for (int n = 0; n < 50; n++) zeroize($urandom % 100, 2'($urandom), ($urandom % 5) == 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule